// File: doc/BRIEF.md
# Address Translation Front End

This block stands between a load/store/fetch unit and its TLB. For every request it picks one of four translation paths, in fixed priority order. The first is direct physical addressing, used when the direct-address control bit is set and paging is off. The second is a bank of four direct-mapped windows, each enabled separately for privilege level 0 (kernel) and level 3 (user). The third is a bad-address fault, raised when the upper address bits are not a proper sign extension. The last path is the result reported by the external TLB. The block returns a physical address and permissions, or an exception code chosen by fault type and access type.

As side effects, a fault updates one of two sets of registers. A TLB miss (refill fault) loads the refill bad-address register and the refill page-number field, and sets a refill-pending flag. Every other fault loads the entry-hi register and, unless debug hold is active, the ordinary bad-address register. The TLB is not part of this block. The caller presents the TLB's result code, physical address and permissions in the same cycle as the request.

Top module: `xlat_front`

## Requirements
- R1: When `mode_direct` is 1 and `mode_paging` is 0, the result is `req_vaddr[47:0]` zero-extended, with permissions 3'b111 (bit0 read, bit1 write, bit2 execute) and no exception. This path wins over windows, the address check and the TLB.
- R2: Windows 0 to 3 are checked in index order, and the lowest index that hits wins. A window hits when its enable bit for the current level is set (bit 0 when `req_user`=0, bit 3 when `req_user`=1) and its segment field equals the address's: bits [63:60] in 64-bit mode (`mode_wide`=1), bits [31:29] in 32-bit mode.
- R3: A window hit in 64-bit mode gives `req_vaddr[47:0]` zero-extended, with permissions 3'b111.
- R4: A window hit in 32-bit mode gives the window's bits [27:25] as physical address bits [31:29], `req_vaddr[28:0]` below them, and zeros above bit 31, with permissions 3'b111.
- R5: With no direct access and no window hit in 64-bit mode, `req_vaddr[63:48]` must be all zeros or all ones. Otherwise the TLB result is ignored and the block raises code 8 for a fetch (`req_kind`=2) or code 9 for a load (0), store (1) or kind 3. In 32-bit mode this check is skipped.
- R6: On the TLB path, result code 0 (hit) passes `tlb_paddr` and `tlb_perm` through with no exception.
- R7: TLB result 1 (miss) and 2 (invalid entry) raise code 1 for a load or kind 3, code 2 for a store and code 3 for a fetch.
- R8: TLB result 6 (not dirty) raises code 4, 3 (read inhibited) raises code 5, 4 (execute inhibited) raises code 6 and 5 (privilege) raises code 7. The unused result 7 raises the address-error code of R5.
- R9: A miss fault loads `refill_badv` with the address and `refill_vppn` with `req_vaddr[47:13]` (64-bit mode) or `req_vaddr[31:13]` zero-extended (32-bit mode), and sets `refill_pending`. `badv` and `entryhi` keep their values. `refill_clr` clears `refill_pending` unless a miss sets it in the same cycle.
- R10: Any other fault loads `entryhi` with the address with bits [12:0] cleared, and loads `badv` with the address only while `dbg_hold` is 0. The refill registers keep their values.
- R11: Results are registered and appear one clock after `req_valid`. `out_valid` is high exactly in the cycle after a request. When there is no result, or when there is an exception, `out_paddr` and `out_perm` are zero, and `exc_valid` is low whenever `out_valid` is low.
- R12: After reset every output and every fault register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_user | input | 1 | 1 = level 3, 0 = level 0 |
| mode_direct | input | 1 | Direct-address control bit |
| mode_paging | input | 1 | Paging control bit |
| mode_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| dbg_hold | input | 1 | Debug status; blocks `badv` updates |
| win_cfg | input | 4x64 | Window registers (enables, segment, physical segment) |
| tlb_result | input | 3 | TLB outcome code for this request |
| tlb_paddr | input | 64 | TLB physical address on hit |
| tlb_perm | input | 3 | TLB permissions on hit |
| refill_clr | input | 1 | Clears the refill-pending flag |
| out_valid | output | 1 | Result present |
| out_paddr | output | 64 | Physical address |
| out_perm | output | 3 | Permissions (read, write, execute) |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 6 | Exception code |
| badv | output | 64 | Ordinary bad-address register |
| entryhi | output | 64 | Entry-hi register |
| refill_badv | output | 64 | Refill bad-address register |
| refill_vppn | output | 35 | Refill page-number field |
| refill_pending | output | 1 | Refill fault in progress |

## Verification
All results and all fault registers come from a single register stage, so each is due at the first rising edge after a request. The bench sets inputs on a falling edge and compares every output and fault register on the next falling edge. It predicts from the requirements and updates its model of the fault registers at that same point. Back-to-back requests therefore each line up with their own result. A clear of the refill flag with no request is checked one clock after it is applied, together with a low `out_valid`.

// File: rtl/xlat_pkg.sv
// Package: shared encodings for the address translation front end.
// Assumes: access kinds and TLB result codes are driven by the caller.
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_SPARE = 2'd3
    } acc_t;

    typedef enum logic [2:0] {
        TR_HIT     = 3'd0,
        TR_MISS    = 3'd1,
        TR_INVALID = 3'd2,
        TR_NOREAD  = 3'd3,
        TR_NOEXEC  = 3'd4,
        TR_PRIV    = 3'd5,
        TR_DIRTY   = 3'd6,
        TR_SPARE   = 3'd7
    } tres_t;

    localparam logic [2:0] PERM_ALL = 3'b111;

endpackage

// File: rtl/xlat_window_match.sv
// Module: direct-mapped window bank with fixed priority.
// Does: checks each window's level enable and segment against the address.
//       The lowest index that hits supplies the translated address.
// Assumes: in 32-bit mode only the low 32 address bits are meaningful.
module xlat_window_match #(
    parameter int XLEN       = 64,
    parameter int VA_BITS    = 48,
    parameter int NWIN       = 4,
    parameter int SEG64_LSB  = 60,
    parameter int SEG32_LSB  = 29,
    parameter int PSEG32_LSB = 25,
    parameter int EN_LO_BIT  = 0,
    parameter int EN_HI_BIT  = 3
) (
    input  logic [XLEN-1:0]            vaddr,
    input  logic                       wide,
    input  logic                       user,
    input  logic [NWIN-1:0][XLEN-1:0]  cfg,
    output logic                       hit,
    output logic [XLEN-1:0]            paddr
);
    localparam int SEG32_W = 32 - SEG32_LSB;
    localparam int SEL_W   = (NWIN > 1) ? $clog2(NWIN) : 1;

    logic [NWIN-1:0]  match;
    logic [SEL_W-1:0] sel;
    logic             unused_cfg;

    assign unused_cfg = ^cfg;

    // One comparator per window: level enable and segment equality.
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic en_g;
        logic seg_eq_g;
        assign en_g     = user ? cfg[g][EN_HI_BIT] : cfg[g][EN_LO_BIT];
        assign seg_eq_g = wide ? (cfg[g][XLEN-1:SEG64_LSB] == vaddr[XLEN-1:SEG64_LSB])
                               : (cfg[g][31:SEG32_LSB] == vaddr[31:SEG32_LSB]);
        assign match[g] = en_g & seg_eq_g;
    end

    // Priority pick: scanning down leaves the lowest hitting index selected.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end

    // Address build for the selected window in either mode.
    always_comb begin
        if (wide) begin
            paddr = {{(XLEN-VA_BITS){1'b0}}, vaddr[VA_BITS-1:0]};
        end else begin
            paddr = {{(XLEN-32){1'b0}},
                     cfg[sel][PSEG32_LSB+SEG32_W-1:PSEG32_LSB],
                     vaddr[SEG32_LSB-1:0]};
        end
    end

endmodule

// File: rtl/xlat_fault_encode.sv
// Module: fault classifier.
// Does: turns an address-check failure or a TLB result into an exception
//       code, using the access kind where the code depends on it.
// Assumes: tres is only meaningful when tlb_path is high.
module xlat_fault_encode
    import xlat_pkg::*;
#(
    parameter int              EC_W          = 6,
    parameter logic [EC_W-1:0] EC_LOAD_INV   = 1,
    parameter logic [EC_W-1:0] EC_STORE_INV  = 2,
    parameter logic [EC_W-1:0] EC_FETCH_INV  = 3,
    parameter logic [EC_W-1:0] EC_MODIFY     = 4,
    parameter logic [EC_W-1:0] EC_NOREAD     = 5,
    parameter logic [EC_W-1:0] EC_NOEXEC     = 6,
    parameter logic [EC_W-1:0] EC_PRIV       = 7,
    parameter logic [EC_W-1:0] EC_FETCH_ADDR = 8,
    parameter logic [EC_W-1:0] EC_MEM_ADDR   = 9
) (
    input  logic            addr_err,
    input  logic            tlb_path,
    input  logic [1:0]      kind,
    input  logic [2:0]      tres,
    output logic            raise,
    output logic [EC_W-1:0] code,
    output logic            miss
);
    logic            is_fetch;
    logic [EC_W-1:0] inv_code;
    logic [EC_W-1:0] adr_code;

    assign is_fetch = (acc_t'(kind) == ACC_FETCH);
    assign adr_code = is_fetch ? EC_FETCH_ADDR : EC_MEM_ADDR;

    // Page-invalid code chosen by access kind.
    always_comb begin
        case (acc_t'(kind))
            ACC_FETCH: inv_code = EC_FETCH_INV;
            ACC_STORE: inv_code = EC_STORE_INV;
            default:   inv_code = EC_LOAD_INV;
        endcase
    end

    // Fault classification: address error first, then the TLB outcome.
    always_comb begin
        raise = 1'b0;
        code  = '0;
        miss  = 1'b0;
        if (addr_err) begin
            raise = 1'b1;
            code  = adr_code;
        end else if (tlb_path) begin
            case (tres_t'(tres))
                TR_HIT: begin
                    raise = 1'b0;
                end
                TR_MISS: begin
                    raise = 1'b1;
                    code  = inv_code;
                    miss  = 1'b1;
                end
                TR_INVALID: begin
                    raise = 1'b1;
                    code  = inv_code;
                end
                TR_NOREAD: begin
                    raise = 1'b1;
                    code  = EC_NOREAD;
                end
                TR_NOEXEC: begin
                    raise = 1'b1;
                    code  = EC_NOEXEC;
                end
                TR_PRIV: begin
                    raise = 1'b1;
                    code  = EC_PRIV;
                end
                TR_DIRTY: begin
                    raise = 1'b1;
                    code  = EC_MODIFY;
                end
                default: begin
                    raise = 1'b1;
                    code  = adr_code;
                end
            endcase
        end
    end

endmodule

// File: rtl/xlat_fault_regs.sv
// Module: fault side-effect registers.
// Does: records refill-fault details on a miss and ordinary fault details
//       otherwise. Holds the refill-pending flag.
// Assumes: fire is a single-cycle strobe per faulting request.
module xlat_fault_regs #(
    parameter int XLEN     = 64,
    parameter int VA_BITS  = 48,
    parameter int PAIR_LSB = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fire,
    input  logic                        miss,
    input  logic                        wide,
    input  logic                        dbg_hold,
    input  logic                        clr,
    input  logic [XLEN-1:0]             vaddr,
    output logic [XLEN-1:0]             badv_q,
    output logic [XLEN-1:0]             entryhi_q,
    output logic [XLEN-1:0]             rbadv_q,
    output logic [VA_BITS-PAIR_LSB-1:0] rvppn_q,
    output logic                        rflag_q
);
    localparam int VPPN_W   = VA_BITS - PAIR_LSB;
    localparam int VPPN32_W = 32 - PAIR_LSB;

    logic [VPPN_W-1:0] vppn_nxt;

    // Page-pair number taken from the address for the current mode.
    assign vppn_nxt = wide ? vaddr[VA_BITS-1:PAIR_LSB]
                           : {{(VPPN_W-VPPN32_W){1'b0}}, vaddr[31:PAIR_LSB]};

    // Refill bookkeeping: loaded only by a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbadv_q <= '0;
            rvppn_q <= '0;
            rflag_q <= 1'b0;
        end else begin
            if (fire && miss) begin
                rbadv_q <= vaddr;
                rvppn_q <= vppn_nxt;
                rflag_q <= 1'b1;
            end else if (clr) begin
                rflag_q <= 1'b0;
            end
        end
    end

    // Ordinary fault bookkeeping: loaded by every other fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            badv_q    <= '0;
            entryhi_q <= '0;
        end else if (fire && !miss) begin
            entryhi_q <= {vaddr[XLEN-1:PAIR_LSB], {PAIR_LSB{1'b0}}};
            if (!dbg_hold) begin
                badv_q <= vaddr;
            end
        end
    end

    // R9: a miss leaves the flag set and the ordinary registers unchanged.
    a_r9_miss_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && miss) |=> (rflag_q && $stable(entryhi_q) && $stable(badv_q)));

    // R10: debug hold keeps the ordinary bad-address register unchanged.
    a_r10_hold_keeps_badv: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !miss && dbg_hold) |=> $stable(badv_q));

    // R10: a non-miss fault leaves the refill registers unchanged.
    a_r10_refill_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !miss) |=> ($stable(rbadv_q) && $stable(rvppn_q)));

endmodule

// File: rtl/xlat_front.sv
// Module: address translation front end (top).
// Does: selects direct, window, address-fault or TLB translation, encodes
//       faults and registers the result one clock after the request.
// Assumes: TLB result, address and permissions belong to the request in
//          the same cycle; synchronous active-low reset.
module xlat_front
    import xlat_pkg::*;
#(
    parameter int              XLEN          = 64,
    parameter int              VA_BITS       = 48,
    parameter int              PA_BITS       = 48,
    parameter int              NWIN          = 4,
    parameter int              SEG64_LSB     = 60,
    parameter int              SEG32_LSB     = 29,
    parameter int              PSEG32_LSB    = 25,
    parameter int              EN_LO_BIT     = 0,
    parameter int              EN_HI_BIT     = 3,
    parameter int              PAIR_LSB      = 13,
    parameter int              EC_W          = 6,
    parameter logic [EC_W-1:0] EC_LOAD_INV   = 1,
    parameter logic [EC_W-1:0] EC_STORE_INV  = 2,
    parameter logic [EC_W-1:0] EC_FETCH_INV  = 3,
    parameter logic [EC_W-1:0] EC_MODIFY     = 4,
    parameter logic [EC_W-1:0] EC_NOREAD     = 5,
    parameter logic [EC_W-1:0] EC_NOEXEC     = 6,
    parameter logic [EC_W-1:0] EC_PRIV       = 7,
    parameter logic [EC_W-1:0] EC_FETCH_ADDR = 8,
    parameter logic [EC_W-1:0] EC_MEM_ADDR   = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [XLEN-1:0]             req_vaddr,
    input  logic [1:0]                  req_kind,
    input  logic                        req_user,
    input  logic                        mode_direct,
    input  logic                        mode_paging,
    input  logic                        mode_wide,
    input  logic                        dbg_hold,
    input  logic [NWIN-1:0][XLEN-1:0]   win_cfg,
    input  logic [2:0]                  tlb_result,
    input  logic [XLEN-1:0]             tlb_paddr,
    input  logic [2:0]                  tlb_perm,
    input  logic                        refill_clr,
    output logic                        out_valid,
    output logic [XLEN-1:0]             out_paddr,
    output logic [2:0]                  out_perm,
    output logic                        exc_valid,
    output logic [EC_W-1:0]             exc_code,
    output logic [XLEN-1:0]             badv,
    output logic [XLEN-1:0]             entryhi,
    output logic [XLEN-1:0]             refill_badv,
    output logic [VA_BITS-PAIR_LSB-1:0] refill_vppn,
    output logic                        refill_pending
);
    localparam int HI_W = XLEN - VA_BITS;

    logic            direct;
    logic            win_hit;
    logic [XLEN-1:0] win_paddr;
    logic            sign_ok;
    logic            addr_err;
    logic            tlb_path;
    logic            raise;
    logic            miss;
    logic [EC_W-1:0] code;
    logic [XLEN-1:0] nxt_paddr;
    logic [2:0]      nxt_perm;

    // Path selection in priority order: direct, window, address check, TLB.
    assign direct   = mode_direct && !mode_paging;
    assign sign_ok  = (req_vaddr[XLEN-1:VA_BITS] == {HI_W{1'b0}}) ||
                      (req_vaddr[XLEN-1:VA_BITS] == {HI_W{1'b1}});
    assign addr_err = !direct && !win_hit && mode_wide && !sign_ok;
    assign tlb_path = !direct && !win_hit && !addr_err;

    xlat_window_match #(
        .XLEN(XLEN), .VA_BITS(VA_BITS), .NWIN(NWIN),
        .SEG64_LSB(SEG64_LSB), .SEG32_LSB(SEG32_LSB), .PSEG32_LSB(PSEG32_LSB),
        .EN_LO_BIT(EN_LO_BIT), .EN_HI_BIT(EN_HI_BIT)
    ) u_win (
        .vaddr (req_vaddr),
        .wide  (mode_wide),
        .user  (req_user),
        .cfg   (win_cfg),
        .hit   (win_hit),
        .paddr (win_paddr)
    );

    xlat_fault_encode #(
        .EC_W(EC_W), .EC_LOAD_INV(EC_LOAD_INV), .EC_STORE_INV(EC_STORE_INV),
        .EC_FETCH_INV(EC_FETCH_INV), .EC_MODIFY(EC_MODIFY),
        .EC_NOREAD(EC_NOREAD), .EC_NOEXEC(EC_NOEXEC), .EC_PRIV(EC_PRIV),
        .EC_FETCH_ADDR(EC_FETCH_ADDR), .EC_MEM_ADDR(EC_MEM_ADDR)
    ) u_enc (
        .addr_err (addr_err),
        .tlb_path (tlb_path),
        .kind     (req_kind),
        .tres     (tlb_result),
        .raise    (raise),
        .code     (code),
        .miss     (miss)
    );

    xlat_fault_regs #(
        .XLEN(XLEN), .VA_BITS(VA_BITS), .PAIR_LSB(PAIR_LSB)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (req_valid && raise),
        .miss      (miss),
        .wide      (mode_wide),
        .dbg_hold  (dbg_hold),
        .clr       (refill_clr),
        .vaddr     (req_vaddr),
        .badv_q    (badv),
        .entryhi_q (entryhi),
        .rbadv_q   (refill_badv),
        .rvppn_q   (refill_vppn),
        .rflag_q   (refill_pending)
    );

    // Next address and permissions for the chosen path; zero on a fault.
    always_comb begin
        nxt_paddr = '0;
        nxt_perm  = '0;
        if (direct) begin
            nxt_paddr = {{(XLEN-PA_BITS){1'b0}}, req_vaddr[PA_BITS-1:0]};
            nxt_perm  = PERM_ALL;
        end else if (win_hit) begin
            nxt_paddr = win_paddr;
            nxt_perm  = PERM_ALL;
        end else if (!raise) begin
            nxt_paddr = tlb_paddr;
            nxt_perm  = tlb_perm;
        end
    end

    // Result register: one clock after the request, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_perm  <= '0;
            exc_valid <= 1'b0;
            exc_code  <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_paddr <= nxt_paddr;
                out_perm  <= nxt_perm;
                exc_valid <= raise;
                exc_code  <= code;
            end else begin
                out_paddr <= '0;
                out_perm  <= '0;
                exc_valid <= 1'b0;
                exc_code  <= '0;
            end
        end
    end

    // R11: a result follows each request by exactly one clock.
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !exc_valid));

    // R1: direct access grants everything and never faults.
    a_r1_direct_full: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_direct && !mode_paging) |=> (out_perm == PERM_ALL && !exc_valid));

    // R5: a bad upper part with no window hit in 64-bit mode faults.
    a_r5_sign_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !direct && !win_hit && mode_wide && !sign_ok) |=> exc_valid);

    // R6: a TLB hit passes the TLB address through.
    a_r6_tlb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tlb_path && tlb_result == 3'd0) |=> (out_paddr == $past(tlb_paddr)));

endmodule

// File: tb/xlat_front_test.sv
`timescale 1ns/1ps
module xlat_front_test;

    localparam time TCK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        req_user;
    logic        mode_direct;
    logic        mode_paging;
    logic        mode_wide;
    logic        dbg_hold;
    logic [3:0][63:0] win_cfg;
    logic [2:0]  tlb_result;
    logic [63:0] tlb_paddr;
    logic [2:0]  tlb_perm;
    logic        refill_clr;
    logic        out_valid;
    logic [63:0] out_paddr;
    logic [2:0]  out_perm;
    logic        exc_valid;
    logic [5:0]  exc_code;
    logic [63:0] badv;
    logic [63:0] entryhi;
    logic [63:0] refill_badv;
    logic [34:0] refill_vppn;
    logic        refill_pending;

    always #(TCK/2) clk = ~clk;

    xlat_front uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .mode_direct(mode_direct),
        .mode_paging(mode_paging), .mode_wide(mode_wide), .dbg_hold(dbg_hold),
        .win_cfg(win_cfg), .tlb_result(tlb_result), .tlb_paddr(tlb_paddr),
        .tlb_perm(tlb_perm), .refill_clr(refill_clr), .out_valid(out_valid),
        .out_paddr(out_paddr), .out_perm(out_perm), .exc_valid(exc_valid),
        .exc_code(exc_code), .badv(badv), .entryhi(entryhi),
        .refill_badv(refill_badv), .refill_vppn(refill_vppn),
        .refill_pending(refill_pending)
    );

    int checks = 0;
    int errors = 0;

    logic        e_exc;
    logic [5:0]  e_code;
    logic [63:0] e_paddr;
    logic [2:0]  e_perm;
    logic [63:0] m_badv, m_ehi, m_rbadv;
    logic [34:0] m_rvppn;
    logic        m_rflag;
    string       tag_out, tag_reg;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] addr_code(input logic [1:0] k);
        return (k == 2'd2) ? 6'd8 : 6'd9;
    endfunction

    // Prediction from the requirements; also advances the fault register model.
    task automatic predict();
        logic        hit;
        logic        miss;
        logic [63:0] wp;
        logic        en, seq;
        hit = 1'b0; miss = 1'b0; wp = '0;
        e_exc = 1'b0; e_code = '0; e_paddr = '0; e_perm = '0;
        for (int i = 0; i < 4; i++) begin
            en  = req_user ? win_cfg[i][3] : win_cfg[i][0];
            seq = mode_wide ? (win_cfg[i][63:60] == req_vaddr[63:60])
                            : (win_cfg[i][31:29] == req_vaddr[31:29]);
            if (!hit && en && seq) begin
                hit = 1'b1;
                wp = mode_wide ? {16'h0, req_vaddr[47:0]}
                               : {32'h0, win_cfg[i][27:25], req_vaddr[28:0]};
            end
        end
        if (mode_direct && !mode_paging) begin
            e_paddr = {16'h0, req_vaddr[47:0]}; e_perm = 3'b111; tag_out = "R1 direct";
        end else if (hit) begin
            e_paddr = wp; e_perm = 3'b111;
            tag_out = mode_wide ? "R2 R3 window" : "R2 R4 window";
        end else if (mode_wide && req_vaddr[63:48] != 16'h0 && req_vaddr[63:48] != 16'hffff) begin
            e_exc = 1'b1; e_code = addr_code(req_kind); tag_out = "R5 address";
        end else begin
            tag_out = "R8 tlb fault";
            case (tlb_result)
                3'd0: begin e_paddr = tlb_paddr; e_perm = tlb_perm; tag_out = "R6 tlb hit"; end
                3'd1, 3'd2: begin
                    e_exc = 1'b1; miss = (tlb_result == 3'd1); tag_out = "R7 invalid/miss";
                    e_code = (req_kind == 2'd2) ? 6'd3 : (req_kind == 2'd1) ? 6'd2 : 6'd1;
                end
                3'd3: begin e_exc = 1'b1; e_code = 6'd5; end
                3'd4: begin e_exc = 1'b1; e_code = 6'd6; end
                3'd5: begin e_exc = 1'b1; e_code = 6'd7; end
                3'd6: begin e_exc = 1'b1; e_code = 6'd4; end
                default: begin e_exc = 1'b1; e_code = addr_code(req_kind); end
            endcase
        end
        if (e_exc && miss) begin
            m_rflag = 1'b1; m_rbadv = req_vaddr;
            m_rvppn = mode_wide ? req_vaddr[47:13] : {16'h0, req_vaddr[31:13]};
            tag_reg = "R9 refill regs";
        end else begin
            if (e_exc) begin
                m_ehi = {req_vaddr[63:13], 13'h0};
                if (!dbg_hold) m_badv = req_vaddr;
            end
            if (refill_clr) m_rflag = 1'b0;
            tag_reg = "R10 fault regs";
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, badv, m_badv);
        chk(tag, entryhi, m_ehi);
        chk(tag, refill_badv, m_rbadv);
        chk(tag, {29'h0, refill_vppn}, {29'h0, m_rvppn});
        chk(tag, {63'h0, refill_pending}, {63'h0, m_rflag});
    endtask

    // Called at a falling edge with inputs set; checks at the next falling edge.
    task automatic run_req();
        req_valid = 1'b1;
        predict();
        @(negedge clk);
        chk({tag_out, " R11 valid"}, {63'h0, out_valid}, 64'h1);
        chk({tag_out, " exc"}, {63'h0, exc_valid}, {63'h0, e_exc});
        chk({tag_out, " code"}, {58'h0, exc_code}, {58'h0, e_code});
        chk({tag_out, " paddr"}, out_paddr, e_paddr);
        chk({tag_out, " perm"}, {61'h0, out_perm}, {61'h0, e_perm});
        check_regs(tag_reg);
        req_valid = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(TCK * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_user = 1'b0;
        mode_direct = 1'b0; mode_paging = 1'b1; mode_wide = 1'b1; dbg_hold = 1'b0;
        win_cfg = '0; tlb_result = '0; tlb_paddr = '0; tlb_perm = '0; refill_clr = 1'b0;
        m_badv = '0; m_ehi = '0; m_rbadv = '0; m_rvppn = '0; m_rflag = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 out_valid", {63'h0, out_valid}, 64'h0);
        chk("R12 exc_valid", {63'h0, exc_valid}, 64'h0);
        chk("R12 paddr", out_paddr, 64'h0);
        check_regs("R12 regs");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: direct access overrides windows and bad upper bits
        win_cfg[0] = {4'hd, 56'h0} | 64'h9;
        for (int d = 0; d < 4; d++) begin
            mode_direct = d[0]; mode_paging = d[1];
            req_vaddr = 64'hdead_beef_0123_4567; req_kind = 2'(d % 3); tlb_result = 3'd1;
            run_req();
        end
        win_cfg = '0;
        mode_direct = 1'b0; mode_paging = 1'b1;

        // R2/R3/R4: window sweep over mode, level, index, enables, segment match
        for (int wd = 0; wd < 2; wd++)
            for (int u = 0; u < 2; u++)
                for (int w = 0; w < 4; w++)
                    for (int en = 0; en < 4; en++)
                        for (int m = 0; m < 2; m++) begin
                            mode_wide = wd[0]; req_user = u[0]; win_cfg = '0;
                            win_cfg[w][63:60] = 4'h9; win_cfg[w][31:29] = 3'b101;
                            win_cfg[w][27:25] = 3'(w + 1);
                            win_cfg[w][0] = en[0]; win_cfg[w][3] = en[1];
                            req_vaddr = wd[0] ? 64'h9000_1234_5678_9abc : 64'h0000_0000_b0bc_def1;
                            if (m == 1) req_vaddr = req_vaddr ^ (wd[0] ? 64'h2000_0000_0000_0000 : 64'h2000_0000);
                            req_kind = 2'(w % 3); tlb_result = 3'd1;
                            tlb_paddr = 64'h55; tlb_perm = 3'b001;
                            run_req();
                        end

        // R2: priority between two hitting windows (32-bit mode)
        mode_wide = 1'b0; req_user = 1'b0; win_cfg = '0;
        win_cfg[1] = 64'ha400_0001; win_cfg[2] = 64'ha600_0001;
        req_vaddr = 64'h0000_0000_a123_4567;
        run_req();
        win_cfg[1] = 64'ha400_0008;
        run_req();
        win_cfg = '0;

        // R5: upper-bit patterns in 64-bit mode, with TLB result ignored on fault
        mode_wide = 1'b1;
        for (int h = 0; h < 6; h++)
            for (int k = 0; k < 4; k++)
                for (int t = 0; t < 2; t++) begin
                    case (h)
                        0: req_vaddr[63:48] = 16'h0000;
                        1: req_vaddr[63:48] = 16'hffff;
                        2: req_vaddr[63:48] = 16'h0001;
                        3: req_vaddr[63:48] = 16'h8000;
                        4: req_vaddr[63:48] = 16'h7fff;
                        default: req_vaddr[63:48] = 16'hfffe;
                    endcase
                    req_vaddr[47:0] = 48'h8765_4321_0000 + 48'(h * 4 + k);
                    req_kind = 2'(k); tlb_result = t[0] ? 3'd0 : 3'd6;
                    tlb_paddr = 64'h0000_0012_3456_7000; tlb_perm = 3'b101; dbg_hold = t[0];
                    run_req();
                end
        // R5: 32-bit mode skips the upper-bit check
        mode_wide = 1'b0; req_vaddr = 64'h1234_0000_0000_5000; tlb_result = 3'd0;
        run_req();

        // R6/R7/R8/R9/R10: TLB result sweep over mode, code, kind and debug hold
        for (int wd = 0; wd < 2; wd++)
            for (int c = 0; c < 8; c++)
                for (int k = 0; k < 4; k++)
                    for (int dh = 0; dh < 2; dh++) begin
                        int it;
                        it = ((wd * 8 + c) * 4 + k) * 2 + dh;
                        mode_wide = wd[0]; tlb_result = 3'(c); req_kind = 2'(k); dbg_hold = dh[0];
                        req_vaddr = 64'h0000_5a00_0000_0000 + 64'(it) * 64'h1_2345_6789;
                        tlb_paddr = req_vaddr ^ 64'h0000_0000_00f0_0000;
                        tlb_perm = 3'(it);
                        run_req();
                    end

        // R9/R11: clear of the refill flag with no request; idle outputs
        refill_clr = 1'b1;
        @(negedge clk);
        m_rflag = 1'b0;
        chk("R9 refill clear", {63'h0, refill_pending}, 64'h0);
        chk("R11 idle valid", {63'h0, out_valid}, 64'h0);
        chk("R11 idle exc", {63'h0, exc_valid}, 64'h0);
        chk("R11 idle paddr", out_paddr, 64'h0);
        // R9: a miss wins over a simultaneous clear
        mode_wide = 1'b1; tlb_result = 3'd1; req_kind = 2'd1; req_vaddr = 64'hffff_8000_4000_3fff;
        run_req();
        refill_clr = 1'b0;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule